// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the byte-wide programming port of an eight-line interrupt controller. Software reaches it through two addresses. On the even address it accepts the opening word of a setup sequence and two kinds of run-time command. On the odd address it accepts the remaining setup words, or the line mask when no setup is in progress. The block turns these writes into plain control fields and single-cycle command strobes for a separate priority resolver. Readback of the request and in-service vectors and of the poll answer goes through a multiplexer fed by that resolver.

A separate one-byte port holds the per-line trigger-mode selection. Each bit is forced to zero where the `TRIG_KEEP` parameter has a zero, so a line that must stay edge-triggered can never be switched. That parameter is fixed at build time and is not changed by a setup sequence. Register accesses are single-cycle strobes with no back-pressure: a write is taken on the clock edge where `wr_en` is high, and read data is combinational in the cycle where `rd_en` is high.

Top module: `irqc_cmd_port`

## Requirements
- R1: After reset the setup sequence is idle (`init_busy`=0), and every control field, the mask, the trigger register, `cfg_err` and all strobes are 0.
- R2: A write to address 0 with bit 4 set (a start word) clears the mask, trigger register, vector base, auto-EOI, fully-nested, poll, read-select, special-mask, rotate-on-auto-EOI and pending strobes. It records bit 0 as "fourth word wanted", enters the wait-for-second-word state (`init_busy`=1) and pulses `init_clr` in the following cycle.
- R3: The first address-1 write after a start word loads `vec_base` from data bits 7:3.
- R4: The next address-1 write (third word) is consumed without effect. If the fourth word was wanted, one more address-1 write follows: bit 4 sets `fully_nested` and bit 1 sets `auto_eoi`. After the last word `init_busy` returns to 0.
- R5: With `init_busy`=0, an address-1 write loads `mask_q`.
- R6: An address-0 write with bit 4 clear and bit 3 set arms poll when bit 2 is 1. It loads `rd_isr_sel` from bit 0 only when bit 1 is 1, and loads `spec_mask` from bit 5 only when bit 6 is 1.
- R7: An address-0 write with bits 4 and 3 clear carries a command in bits 7:5. Codes 0 and 4 load `rot_aeoi` from bit 7. Codes 1, 3, 5, 6 and 7 raise `cmd_stb` for the one following cycle, with `cmd_kind` equal to the code and `cmd_lvl` equal to bits 2:0. Code 2 changes nothing.
- R8: With poll not armed, a read of address 0 returns `isr_in` when `rd_isr_sel`=1 and `irr_in` otherwise; a read of address 1 returns `mask_q`.
- R9: With poll armed, a read at either address returns `poll_in` and raises `poll_take` in that cycle, and poll is disarmed from the next cycle.
- R10: A trigger-port write loads `trig_q` with `trig_wdata & TRIG_KEEP`; a start word clears it.
- R11: A start word with bit 1 or bit 3 set sets `cfg_err`; a start word with both clear clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while rd_en is high |
| trig_wr | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 8 | Trigger-mode write data |
| trig_q | output | 8 | Trigger-mode selection per line (1 = level) |
| isr_in | input | 8 | In-service vector from the resolver |
| irr_in | input | 8 | Request vector from the resolver |
| poll_in | input | 8 | Poll answer from the resolver |
| poll_take | output | 1 | A poll read is being made this cycle |
| init_clr | output | 1 | One-cycle pulse telling the resolver to clear its state |
| init_busy | output | 1 | Setup sequence in progress |
| vec_base | output | 5 | Upper bits of the vector number |
| auto_eoi | output | 1 | Automatic end-of-interrupt mode |
| fully_nested | output | 1 | Special fully nested mode |
| rd_isr_sel | output | 1 | Readback select: 1 = in-service, 0 = request |
| poll_armed | output | 1 | Next read is a poll |
| spec_mask | output | 1 | Special mask mode |
| rot_aeoi | output | 1 | Rotate priority on automatic end-of-interrupt |
| mask_q | output | 8 | Line mask |
| cmd_stb | output | 1 | Command strobe for the resolver |
| cmd_kind | output | 3 | Command code, valid with cmd_stb |
| cmd_lvl | output | 3 | Line operand, valid with cmd_stb |
| cfg_err | output | 1 | Unsupported mode asked for in the start word |

## Verification
A wrong setup state would send the next address-1 write to the wrong place: a mask write would land in `vec_base`, or a setup word would load `mask_q`. Either shows on the ports in the cycle after that write. A wrongly held poll flag changes `rdata` and `poll_take` on the very next read. A wrongly decoded command shows as a missing, extra or mislabelled `cmd_stb` one cycle after the write. The bench therefore compares every output against its reference model on every clock, so a divergence is caught in the cycle where it first becomes visible.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DW = 8;
  localparam int LW = 3;
  localparam int VW = DW - LW;

  typedef enum logic [1:0] {
    ST_RUN = 2'd0,
    ST_W2  = 2'd1,
    ST_W3  = 2'd2,
    ST_W4  = 2'd3
  } init_st_e;

  localparam logic [2:0] OP_AEOI_OFF = 3'd0;
  localparam logic [2:0] OP_NSEOI    = 3'd1;
  localparam logic [2:0] OP_NOP      = 3'd2;
  localparam logic [2:0] OP_SEOI     = 3'd3;
  localparam logic [2:0] OP_AEOI_ON  = 3'd4;
  localparam logic [2:0] OP_RNSEOI   = 3'd5;
  localparam logic [2:0] OP_SETPRI   = 3'd6;
  localparam logic [2:0] OP_RSEOI    = 3'd7;
endpackage

// File: rtl/irqc_init_seq.sv
module irqc_init_seq
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  output logic          start_w,
  output logic          busy,
  output logic          run_wr1,
  output logic [VW-1:0] vec_base,
  output logic          auto_eoi,
  output logic          fully_nested,
  output logic          cfg_err
);
  init_st_e st_q;
  logic     want4_q;
  logic     wr1;

  assign start_w = wr_en && !addr && wdata[4];
  assign wr1     = wr_en && addr;
  assign run_wr1 = wr1 && (st_q == ST_RUN);
  assign busy    = (st_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q         <= ST_RUN;
      want4_q      <= 1'b0;
      vec_base     <= '0;
      auto_eoi     <= 1'b0;
      fully_nested <= 1'b0;
      cfg_err      <= 1'b0;
    end else if (start_w) begin
      st_q         <= ST_W2;
      want4_q      <= wdata[0];
      vec_base     <= '0;
      auto_eoi     <= 1'b0;
      fully_nested <= 1'b0;
      cfg_err      <= wdata[1] | wdata[3];
    end else if (wr1) begin
      unique case (st_q)
        ST_W2: begin
          vec_base <= wdata[DW-1:LW];
          st_q     <= ST_W3;
        end
        ST_W3: st_q <= want4_q ? ST_W4 : ST_RUN;
        ST_W4: begin
          fully_nested <= wdata[4];
          auto_eoi     <= wdata[1];
          st_q         <= ST_RUN;
        end
        default: st_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/irqc_op_dec.sv
module irqc_op_dec
  import irqc_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic          addr,
  input  logic [DW-1:0] wdata,
  input  logic          start_w,
  output logic          poll_armed,
  output logic          rd_isr_sel,
  output logic          spec_mask,
  output logic          rot_aeoi,
  output logic          cmd_stb,
  output logic [2:0]    cmd_kind,
  output logic [LW-1:0] cmd_lvl
);
  logic       wr0_cmd;
  logic       sel_w;
  logic       ctl_w;
  logic [2:0] code;
  logic       strobing;

  assign wr0_cmd = wr_en && !addr && !wdata[4];
  assign sel_w   = wr0_cmd && wdata[3];
  assign ctl_w   = wr0_cmd && !wdata[3];
  assign code    = wdata[7:5];

  always_comb begin
    unique case (code)
      OP_NSEOI, OP_SEOI, OP_RNSEOI, OP_SETPRI, OP_RSEOI: strobing = 1'b1;
      default:                                          strobing = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_armed <= 1'b0;
      rd_isr_sel <= 1'b0;
      spec_mask  <= 1'b0;
      rot_aeoi   <= 1'b0;
      cmd_stb    <= 1'b0;
      cmd_kind   <= '0;
      cmd_lvl    <= '0;
    end else if (start_w) begin
      poll_armed <= 1'b0;
      rd_isr_sel <= 1'b0;
      spec_mask  <= 1'b0;
      rot_aeoi   <= 1'b0;
      cmd_stb    <= 1'b0;
    end else begin
      cmd_stb <= 1'b0;
      if (sel_w && wdata[2])
        poll_armed <= 1'b1;
      else if (rd_en && poll_armed)
        poll_armed <= 1'b0;
      if (sel_w && wdata[1]) rd_isr_sel <= wdata[0];
      if (sel_w && wdata[6]) spec_mask  <= wdata[5];
      if (ctl_w && (code == OP_AEOI_OFF || code == OP_AEOI_ON))
        rot_aeoi <= wdata[7];
      if (ctl_w && strobing) begin
        cmd_stb  <= 1'b1;
        cmd_kind <= code;
        cmd_lvl  <= wdata[LW-1:0];
      end
    end
  end
endmodule

// File: rtl/irqc_rd_mux.sv
module irqc_rd_mux
  import irqc_pkg::*;
(
  input  logic          addr,
  input  logic          poll_armed,
  input  logic          rd_isr_sel,
  input  logic [DW-1:0] isr_in,
  input  logic [DW-1:0] irr_in,
  input  logic [DW-1:0] poll_in,
  input  logic [DW-1:0] mask_q,
  output logic [DW-1:0] rdata
);
  always_comb begin
    if (poll_armed)      rdata = poll_in;
    else if (addr)       rdata = mask_q;
    else if (rd_isr_sel) rdata = isr_in;
    else                 rdata = irr_in;
  end
endmodule

// File: rtl/irqc_cmd_port.sv
module irqc_cmd_port
  import irqc_pkg::*;
#(
  parameter logic [7:0] TRIG_KEEP = 8'hF8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic       addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       trig_wr,
  input  logic [7:0] trig_wdata,
  output logic [7:0] trig_q,
  input  logic [7:0] isr_in,
  input  logic [7:0] irr_in,
  input  logic [7:0] poll_in,
  output logic       poll_take,
  output logic       init_clr,
  output logic       init_busy,
  output logic [4:0] vec_base,
  output logic       auto_eoi,
  output logic       fully_nested,
  output logic       rd_isr_sel,
  output logic       poll_armed,
  output logic       spec_mask,
  output logic       rot_aeoi,
  output logic [7:0] mask_q,
  output logic       cmd_stb,
  output logic [2:0] cmd_kind,
  output logic [2:0] cmd_lvl,
  output logic       cfg_err
);
  logic start_w;
  logic run_wr1;

  irqc_init_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .start_w(start_w), .busy(init_busy), .run_wr1(run_wr1),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .fully_nested(fully_nested),
    .cfg_err(cfg_err)
  );

  irqc_op_dec u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .start_w(start_w), .poll_armed(poll_armed),
    .rd_isr_sel(rd_isr_sel), .spec_mask(spec_mask), .rot_aeoi(rot_aeoi),
    .cmd_stb(cmd_stb), .cmd_kind(cmd_kind), .cmd_lvl(cmd_lvl)
  );

  irqc_rd_mux u_mux (
    .addr(addr), .poll_armed(poll_armed), .rd_isr_sel(rd_isr_sel),
    .isr_in(isr_in), .irr_in(irr_in), .poll_in(poll_in), .mask_q(mask_q),
    .rdata(rdata)
  );

  assign poll_take = rd_en && poll_armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      trig_q   <= '0;
      init_clr <= 1'b0;
    end else begin
      init_clr <= start_w;
      if (start_w) begin
        mask_q <= '0;
        trig_q <= '0;
      end else begin
        if (run_wr1) mask_q <= wdata;
        if (trig_wr) trig_q <= trig_wdata & TRIG_KEEP;
      end
    end
  end
endmodule

// File: rtl/irqc_cmd_port_chk.sv
module irqc_cmd_port_chk #(
  parameter logic [7:0] TRIG_KEEP = 8'hF8
) (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic       rd_en,
  input logic       addr,
  input logic [7:0] wdata,
  input logic [7:0] trig_q,
  input logic       poll_armed,
  input logic       poll_take,
  input logic       init_busy,
  input logic       init_clr,
  input logic [7:0] mask_q,
  input logic       cmd_stb,
  input logic [2:0] cmd_kind
);
  // R2
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !addr && wdata[4]) |=> (init_busy && init_clr && mask_q == 8'h00));

  // R5
  mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr) && !(wr_en && !addr && wdata[4]) |=> $stable(mask_q));

  // R7
  cmd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stb |-> (cmd_kind != 3'd0 && cmd_kind != 3'd2 && cmd_kind != 3'd4));

  // R9
  poll_disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_take && !(wr_en && !addr && !wdata[4] && wdata[3] && wdata[2])) |=> !poll_armed);

  // R10
  trig_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_q & ~TRIG_KEEP) == 8'h00);

  // R9
  poll_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    poll_take |-> (rd_en && poll_armed));
endmodule

bind irqc_cmd_port irqc_cmd_port_chk #(.TRIG_KEEP(TRIG_KEEP)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .trig_q(trig_q), .poll_armed(poll_armed),
  .poll_take(poll_take), .init_busy(init_busy), .init_clr(init_clr),
  .mask_q(mask_q), .cmd_stb(cmd_stb), .cmd_kind(cmd_kind)
);

// File: tb/irqc_cmd_port_test.sv
`timescale 1ns/1ps
module irqc_cmd_port_test;
  localparam logic [7:0] KEEP = 8'hDE;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0, trig_wr = 1'b0;
  logic [7:0] wdata = '0, trig_wdata = '0;
  logic [7:0] isr_in = 8'h5A, irr_in = 8'hC3, poll_in = 8'h84;
  logic [7:0] rdata, trig_q, mask_q;
  logic poll_take, init_clr, init_busy, auto_eoi, fully_nested, rd_isr_sel;
  logic poll_armed, spec_mask, rot_aeoi, cmd_stb, cfg_err;
  logic [4:0] vec_base;
  logic [2:0] cmd_kind, cmd_lvl;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irqc_cmd_port #(.TRIG_KEEP(KEEP)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .trig_wr(trig_wr), .trig_wdata(trig_wdata),
    .trig_q(trig_q), .isr_in(isr_in), .irr_in(irr_in), .poll_in(poll_in),
    .poll_take(poll_take), .init_clr(init_clr), .init_busy(init_busy),
    .vec_base(vec_base), .auto_eoi(auto_eoi), .fully_nested(fully_nested),
    .rd_isr_sel(rd_isr_sel), .poll_armed(poll_armed), .spec_mask(spec_mask),
    .rot_aeoi(rot_aeoi), .mask_q(mask_q), .cmd_stb(cmd_stb),
    .cmd_kind(cmd_kind), .cmd_lvl(cmd_lvl), .cfg_err(cfg_err)
  );

  // reference model
  int   m_phase = 0;
  bit   m_want4, m_aeoi, m_fnm, m_err, m_poll, m_sel, m_smm, m_rot, m_stb, m_clr;
  int   m_vec, m_mask, m_trig, m_kind, m_lvl;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_want4 = 0; m_aeoi = 0; m_fnm = 0; m_err = 0; m_poll = 0;
      m_sel = 0; m_smm = 0; m_rot = 0; m_stb = 0; m_clr = 0;
      m_vec = 0; m_mask = 0; m_trig = 0; m_kind = 0; m_lvl = 0;
    end else begin
      m_stb = 0;
      m_clr = 0;
      if (trig_wr) m_trig = trig_wdata & KEEP;
      if (rd_en && m_poll) m_poll = 0;
      if (wr_en && !addr && wdata[4]) begin
        m_phase = 1; m_want4 = wdata[0]; m_clr = 1;
        m_vec = 0; m_aeoi = 0; m_fnm = 0; m_mask = 0; m_trig = 0;
        m_poll = 0; m_sel = 0; m_smm = 0; m_rot = 0;
        m_err = wdata[1] || wdata[3];
      end else if (wr_en && !addr && wdata[3]) begin
        if (wdata[2]) m_poll = 1;
        if (wdata[1]) m_sel = wdata[0];
        if (wdata[6]) m_smm = wdata[5];
      end else if (wr_en && !addr) begin
        int c;
        c = wdata[7:5];
        if (c == 0 || c == 4) m_rot = wdata[7];
        else if (c != 2) begin m_stb = 1; m_kind = c; m_lvl = wdata[2:0]; end
      end else if (wr_en && addr) begin
        if (m_phase == 0) m_mask = wdata;
        else if (m_phase == 1) begin m_vec = wdata >> 3; m_phase = 2; end
        else if (m_phase == 2) m_phase = m_want4 ? 3 : 0;
        else begin m_fnm = wdata[4]; m_aeoi = wdata[1]; m_phase = 0; end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R2", "init_clr", init_clr, m_clr);
      chk("R3", "vec_base", vec_base, m_vec);
      chk("R4", "init_busy", init_busy, m_phase != 0);
      chk("R4", "auto_eoi", auto_eoi, m_aeoi);
      chk("R4", "fully_nested", fully_nested, m_fnm);
      chk("R5", "mask_q", mask_q, m_mask);
      chk("R6", "poll_armed", poll_armed, m_poll);
      chk("R6", "rd_isr_sel", rd_isr_sel, m_sel);
      chk("R6", "spec_mask", spec_mask, m_smm);
      chk("R7", "rot_aeoi", rot_aeoi, m_rot);
      chk("R7", "cmd_stb", cmd_stb, m_stb);
      if (m_stb) begin
        chk("R7", "cmd_kind", cmd_kind, m_kind);
        chk("R7", "cmd_lvl", cmd_lvl, m_lvl);
      end
      chk("R10", "trig_q", trig_q, m_trig);
      chk("R11", "cfg_err", cfg_err, m_err);
    end
  end

  task automatic wr(input bit a, input logic [7:0] d);
    @(negedge clk); #1;
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk); #1;
    wr_en = 0; wdata = 8'h00;
  endtask

  task automatic twr(input logic [7:0] d);
    @(negedge clk); #1;
    trig_wr = 1; trig_wdata = d;
    @(negedge clk); #1;
    trig_wr = 0;
  endtask

  task automatic rd(input bit a, input string req, input logic [7:0] exp, input bit exp_take);
    @(negedge clk); #1;
    rd_en = 1; addr = a;
    #1;
    chk(req, "rdata", rdata, exp);
    chk(req, "poll_take", poll_take, exp_take);
    @(negedge clk); #1;
    rd_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    @(negedge clk); #2;
    // R1: reset values
    chk("R1", "init_busy", init_busy, 0);
    chk("R1", "mask_q", mask_q, 0);
    chk("R1", "cmd_stb", cmd_stb, 0);
    chk("R1", "trig_q", trig_q, 0);
    chk("R1", "cfg_err", cfg_err, 0);

    // R10 trigger masking
    twr(8'hFF);
    chk("R10", "trig_q", trig_q, KEEP);
    // R5 mask in run state
    wr(1, 8'h3C);
    chk("R5", "mask_q", mask_q, 8'h3C);
    rd(1, "R8", 8'h3C, 0);
    rd(0, "R8", irr_in, 0);
    // R2 start word with 4th word wanted
    wr(0, 8'h11);
    chk("R2", "mask_q", mask_q, 0);
    chk("R2", "trig_q", trig_q, 0);
    chk("R2", "init_busy", init_busy, 1);
    wr(1, 8'hAF);
    chk("R3", "vec_base", vec_base, 5'h15);
    wr(1, 8'h04);
    chk("R4", "init_busy", init_busy, 1);
    wr(1, 8'h12);
    chk("R4", "fully_nested", fully_nested, 1);
    chk("R4", "auto_eoi", auto_eoi, 1);
    chk("R4", "init_busy", init_busy, 0);
    wr(1, 8'h81);
    chk("R5", "mask_q", mask_q, 8'h81);
    // R11 error flag
    wr(0, 8'h1A);
    chk("R11", "cfg_err", cfg_err, 1);
    wr(1, 8'h40);
    wr(1, 8'h00);
    chk("R4", "init_busy", init_busy, 0);
    wr(0, 8'h10);
    chk("R11", "cfg_err", cfg_err, 0);
    wr(1, 8'h08); wr(1, 8'h00);
    // R6 select, gated
    wr(0, 8'h0B);
    rd(0, "R8", isr_in, 0);
    wr(0, 8'h09);
    chk("R6", "rd_isr_sel", rd_isr_sel, 1);
    wr(0, 8'h68);
    chk("R6", "spec_mask", spec_mask, 1);
    wr(0, 8'h28);
    chk("R6", "spec_mask", spec_mask, 1);
    // R9 poll
    wr(0, 8'h0C);
    rd(1, "R9", poll_in, 1);
    rd(1, "R9", 8'h00, 0);
    // R7 commands
    for (int c = 0; c < 8; c++) wr(0, 8'((c << 5) | 3'(c + 2)));
    wr(0, 8'h80);
    chk("R7", "rot_aeoi", rot_aeoi, 1);
    wr(0, 8'h40);
    chk("R7", "rot_aeoi", rot_aeoi, 1);
    wr(0, 8'h00);
    chk("R7", "rot_aeoi", rot_aeoi, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule